// File: doc/BRIEF.md
# SPI Slave Command Frame Responder

This block is the protocol layer of an SPI slave. It sits between a byte-wide deserializer/serializer and a simple register bus. Each byte the host clocks in arrives as a one-cycle `rx_valid` strobe. The block parses the command frame and, once the frame is complete, issues at most one register access. It then supplies the bytes that the serializer shifts back to the host during the following byte slots.

The command set has three groups:
- single-word reads and writes with a 24-bit address;
- internal reads and writes with a 16-bit address, whose top bit is a clockless-access flag;
- DMA headers with a 16-bit or 24-bit length, and three control commands (reset, terminate, repeat).

An optional CRC7 byte ends every command frame. Bulk data packets and the bit-level shifting are handled elsewhere.

`tx_byte` always holds the byte for the next slot. It changes only after a byte has been accepted, or after `cs_n` is raised.

Top module: `spi_cmd_responder`

## Requirements
- R1: After reset, `tx_byte` is 0x00, no register access is issued, and the parser waits for an opcode.
- R2: Opcode 0xC9 is followed by a 24-bit address and then 4 data bytes, each field most significant byte first. The block issues one single-cycle `reg_we` pulse with that address and data, with `reg_clockless` = 0. The response is the echoed opcode followed by status 0x00.
- R3: Opcode 0xCA is followed by a 24-bit address, most significant byte first. The block issues one single-cycle `reg_re` pulse and samples `reg_rdata` in that same cycle. The response is: the echo, status 0x00, the header byte 0xF3 (upper nibble 0xF, lower nibble `HDR_TAG`), then the 4 data bytes most significant first. When CRC is on, two 0x00 bytes follow.
- R4: Opcode 0xC3 (internal write, 16-bit address plus 4 data bytes) and opcode 0xC4 (internal read, 16-bit address plus one pad byte that is ignored) give the address {hi[6:0], lo}. Bit 7 of the high address byte appears on `reg_clockless` during the access.
- R5: The DMA opcodes 0xC1/0xC2 carry 3 address bytes and a 2-byte length. The DMA opcodes 0xC7/0xC8 carry 3 address bytes and a 3-byte length. All four answer with the echo and status 0x00 and make no register access.
- R6: The control opcodes 0xC5, 0xC6 and 0xCF carry 3 argument bytes. Each answers with a filler 0x00, then the echo, then status 0x00, and makes no register access.
- R7: When `crc_en` is 1 at the opcode, the frame ends with one extra byte. Bits 7:1 of that byte hold the CRC7 (polynomial x^7+x^3+1, initial value 0x7F, computed MSB first over all earlier frame bytes). On a mismatch the status is 0x02 (`STAT_BAD_CRC`), only the echo and status are returned (with the filler first for control opcodes), and no access is made. When `crc_en` is 0, the frame has no CRC byte and a read has no trailing CRC bytes.
- R8: Any other opcode returns the echo and then status 0x01 (`STAT_BAD_OP`) in the next two slots, with no access. The byte after those two slots is parsed as a new opcode.
- R9: While `cs_n` is high, bytes are ignored, the parser returns to idle and `tx_byte` is 0x00. A partly received frame causes no access, and an interrupted response is dropped.
- R10: While a command frame is being received, `tx_byte` is 0x00. The byte that follows the last response slot is taken as the next opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rx_valid | input | 1 | One-cycle strobe: one byte exchanged on the bus |
| rx_byte | input | 8 | Byte received from the host |
| crc_en | input | 1 | Command frames carry a CRC7 byte |
| tx_byte | output | 8 | Byte to shift out in the next slot |
| reg_addr | output | ADDR_W | Register access address |
| reg_wdata | output | 32 | Register write data |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_re | output | 1 | Read strobe, one cycle |
| reg_clockless | output | 1 | Clockless-access flag of internal commands |
| reg_rdata | input | 32 | Read data, valid in the `reg_re` cycle |

## Verification
The checker assumes that the deserializer never delivers two bytes in consecutive cycles. This spacing is what gives the block time to sample read data before the data slots begin. The checker also assumes that the register port returns data in the same cycle as `reg_re`.

The bench drives each byte as a one-cycle strobe followed by three idle cycles. It models the register port as a combinational function of the address. It changes `crc_en` and `cs_n` only between byte slots.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam logic [7:0] OP_DMA_WR  = 8'hC1;
   localparam logic [7:0] OP_DMA_RD  = 8'hC2;
   localparam logic [7:0] OP_INT_WR  = 8'hC3;
   localparam logic [7:0] OP_INT_RD  = 8'hC4;
   localparam logic [7:0] OP_TERM    = 8'hC5;
   localparam logic [7:0] OP_RPT     = 8'hC6;
   localparam logic [7:0] OP_DMAX_WR = 8'hC7;
   localparam logic [7:0] OP_DMAX_RD = 8'hC8;
   localparam logic [7:0] OP_SGL_WR  = 8'hC9;
   localparam logic [7:0] OP_SGL_RD  = 8'hCA;
   localparam logic [7:0] OP_RESET   = 8'hCF;

   localparam int PAY_MAX = 7;   // longest payload after the opcode
   localparam int LEN_W   = 4;

   typedef enum logic [2:0] {
      K_SGL_WR, K_SGL_RD, K_INT_WR, K_INT_RD, K_CTRL, K_DMA
   } cmd_kind_e;

   typedef enum logic [1:0] {ST_OP, ST_HDR, ST_RSP} parse_st_e;
endpackage

// File: rtl/spi_cmd_crc7.sv
module spi_cmd_crc7 #(
   parameter logic [6:0] POLY = 7'h09,
   parameter int BITS = 8
) (
   input  logic [6:0]      crc_in,
   input  logic [BITS-1:0] data,
   output logic [6:0]      crc_out
);
   logic [7*(BITS+1)-1:0] chain;

   assign chain[6:0] = crc_in;

   for (genvar i = 0; i < BITS; i++) begin : g_bit
      logic fb;
      assign fb = chain[7*i+6] ^ data[BITS-1-i];
      assign chain[7*(i+1) +: 7] = {chain[7*i +: 6], 1'b0} ^ (fb ? POLY : 7'h00);
   end

   assign crc_out = chain[7*BITS +: 7];
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
   import spi_cmd_pkg::*;
(
   input  logic [7:0]       op,
   output logic             known,
   output cmd_kind_e        kind,
   output logic [LEN_W-1:0] pay_len
);
   always_comb begin
      known   = 1'b1;
      kind    = K_CTRL;
      pay_len = LEN_W'(3);
      case (op)
         OP_SGL_WR: begin kind = K_SGL_WR; pay_len = LEN_W'(7); end
         OP_SGL_RD: begin kind = K_SGL_RD; pay_len = LEN_W'(3); end
         OP_INT_WR: begin kind = K_INT_WR; pay_len = LEN_W'(6); end
         OP_INT_RD: begin kind = K_INT_RD; pay_len = LEN_W'(3); end
         OP_DMA_WR, OP_DMA_RD: begin kind = K_DMA; pay_len = LEN_W'(5); end
         OP_DMAX_WR, OP_DMAX_RD: begin kind = K_DMA; pay_len = LEN_W'(6); end
         OP_TERM, OP_RPT, OP_RESET: begin kind = K_CTRL; pay_len = LEN_W'(3); end
         default: known = 1'b0;
      endcase
   end
endmodule

// File: rtl/spi_cmd_responder.sv
module spi_cmd_responder
   import spi_cmd_pkg::*;
#(
   parameter int         ADDR_W       = 24,
   parameter logic [3:0] HDR_TAG      = 4'h3,
   parameter logic [7:0] STAT_BAD_OP  = 8'h01,
   parameter logic [7:0] STAT_BAD_CRC = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              crc_en,
   output logic [7:0]        tx_byte,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [31:0]       reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   output logic              reg_clockless,
   input  logic [31:0]       reg_rdata
);
   localparam int PAY_W     = 8 * PAY_MAX;
   localparam int RSP_SLOTS = 2 ** LEN_W;

   if (ADDR_W < 24) begin : g_chk_addr
      $error("ADDR_W must hold a 24-bit address");
   end
   if (STAT_BAD_OP == 8'h00 || STAT_BAD_CRC == 8'h00) begin : g_chk_stat
      $error("error status codes must be nonzero");
   end
   if (STAT_BAD_OP == STAT_BAD_CRC) begin : g_chk_dist
      $error("error status codes must differ");
   end

   parse_st_e        st_q;
   cmd_kind_e        kind_q;
   logic [7:0]       op_q;
   logic             crc_on_q;
   logic [LEN_W-1:0] left_q, idx_q, last_q;
   logic [PAY_W-1:0] hdr_q;
   logic [6:0]       crc_q;
   logic [7:0]       resp_q [RSP_SLOTS];

   logic             dec_known;
   cmd_kind_e        dec_kind;
   logic [LEN_W-1:0] dec_len;
   logic [6:0]       crc_nxt;

   spi_cmd_decode u_dec (
      .op(rx_byte), .known(dec_known), .kind(dec_kind), .pay_len(dec_len)
   );

   spi_cmd_crc7 u_crc (
      .crc_in(st_q == ST_OP ? 7'h7F : crc_q), .data(rx_byte), .crc_out(crc_nxt)
   );

   // frame-end decode of the collected payload
   logic [PAY_W-1:0] pay;
   logic             crc_bad, is_rd, is_wr;
   logic [23:0]      acc_addr;
   logic             acc_cl;
   logic [7:0]       stat;

   always_comb begin
      pay      = crc_on_q ? hdr_q : {hdr_q[PAY_W-9:0], rx_byte};
      crc_bad  = crc_on_q && (rx_byte[7:1] != crc_q);
      is_rd    = (kind_q == K_SGL_RD) || (kind_q == K_INT_RD);
      is_wr    = (kind_q == K_SGL_WR) || (kind_q == K_INT_WR);
      stat     = crc_bad ? STAT_BAD_CRC : 8'h00;
      acc_cl   = 1'b0;
      acc_addr = pay[23:0];
      case (kind_q)
         K_SGL_WR: acc_addr = pay[55:32];
         K_INT_WR: begin acc_addr = {9'd0, pay[46:32]}; acc_cl = pay[47]; end
         K_INT_RD: begin acc_addr = {9'd0, pay[22:8]};  acc_cl = pay[23]; end
         default:  acc_addr = pay[23:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q          <= ST_OP;
         kind_q        <= K_CTRL;
         op_q          <= 8'h00;
         crc_on_q      <= 1'b0;
         left_q        <= '0;
         idx_q         <= '0;
         last_q        <= '0;
         hdr_q         <= '0;
         crc_q         <= 7'h7F;
         reg_addr      <= '0;
         reg_wdata     <= '0;
         reg_we        <= 1'b0;
         reg_re        <= 1'b0;
         reg_clockless <= 1'b0;
         for (int i = 0; i < RSP_SLOTS; i++) resp_q[i] <= 8'h00;
      end else begin
         reg_we <= 1'b0;
         reg_re <= 1'b0;
         if (reg_re) begin
            resp_q[3] <= reg_rdata[31:24];
            resp_q[4] <= reg_rdata[23:16];
            resp_q[5] <= reg_rdata[15:8];
            resp_q[6] <= reg_rdata[7:0];
         end
         if (cs_n) begin
            st_q  <= ST_OP;
            idx_q <= '0;
         end else if (rx_valid) begin
            case (st_q)
               ST_OP: begin
                  op_q     <= rx_byte;
                  crc_on_q <= crc_en;
                  crc_q    <= crc_nxt;
                  hdr_q    <= '0;
                  idx_q    <= '0;
                  if (dec_known) begin
                     kind_q <= dec_kind;
                     left_q <= dec_len + LEN_W'(crc_en);
                     st_q   <= ST_HDR;
                  end else begin
                     resp_q[0] <= rx_byte;
                     resp_q[1] <= STAT_BAD_OP;
                     last_q    <= LEN_W'(1);
                     st_q      <= ST_RSP;
                  end
               end
               ST_HDR: begin
                  if (left_q == LEN_W'(1)) begin
                     st_q  <= ST_RSP;
                     idx_q <= '0;
                     if (kind_q == K_CTRL) begin
                        resp_q[0] <= 8'h00;
                        resp_q[1] <= op_q;
                        resp_q[2] <= stat;
                        last_q    <= LEN_W'(2);
                     end else begin
                        resp_q[0] <= op_q;
                        resp_q[1] <= stat;
                        last_q    <= LEN_W'(1);
                     end
                     if (!crc_bad && (is_rd || is_wr)) begin
                        reg_addr      <= ADDR_W'(acc_addr);
                        reg_clockless <= acc_cl;
                        reg_wdata     <= pay[31:0];
                        reg_we        <= is_wr;
                        reg_re        <= is_rd;
                     end
                     if (!crc_bad && is_rd) begin
                        resp_q[2] <= {4'hF, HDR_TAG};
                        resp_q[7] <= 8'h00;
                        resp_q[8] <= 8'h00;
                        last_q    <= crc_on_q ? LEN_W'(8) : LEN_W'(6);
                     end
                  end else begin
                     left_q <= left_q - LEN_W'(1);
                     hdr_q  <= {hdr_q[PAY_W-9:0], rx_byte};
                     crc_q  <= crc_nxt;
                  end
               end
               default: begin
                  if (idx_q == last_q) begin
                     st_q  <= ST_OP;
                     idx_q <= '0;
                  end else begin
                     idx_q <= idx_q + LEN_W'(1);
                  end
               end
            endcase
         end
      end
   end

   assign tx_byte = (st_q == ST_RSP) ? resp_q[idx_q] : 8'h00;
endmodule

// File: rtl/spi_cmd_responder_chk.sv
module spi_cmd_responder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       rx_valid,
   input logic [7:0] tx_byte,
   input logic       reg_we,
   input logic       reg_re
);
   // input assumption: bytes arrive at least two cycles apart (R10)
   a_r10_byte_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   a_r2_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   a_r3_re_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   a_r8_one_access_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));

   a_r10_access_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we || reg_re) |-> $past(rx_valid && !cs_n));

   a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (tx_byte == 8'h00) && !reg_we && !reg_re);
endmodule

bind spi_cmd_responder spi_cmd_responder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
   .tx_byte(tx_byte), .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/spi_cmd_responder_test.sv
module spi_cmd_responder_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, cs_n, rx_valid, crc_en;
   logic [7:0]  rx_byte, tx_byte;
   logic [23:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        reg_we, reg_re, reg_clockless;

   spi_cmd_responder uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .crc_en(crc_en), .tx_byte(tx_byte),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_re(reg_re), .reg_clockless(reg_clockless), .reg_rdata(reg_rdata)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [31:0] mem_val(input logic [23:0] a);
      return {a[7:0] ^ 8'h5A, a[15:8], a[23:16], 8'hC3};
   endfunction
   assign reg_rdata = mem_val(reg_addr);

   int n_chk = 0, n_fail = 0, n_we = 0, n_re = 0;
   bit done = 1'b0;
   logic [23:0] w_addr, r_addr;
   logic [31:0] w_data;
   logic        w_cl, r_cl;

   always @(posedge clk) begin
      if (rst_n && reg_we) begin n_we <= n_we + 1; w_addr <= reg_addr; w_data <= reg_wdata; w_cl <= reg_clockless; end
      if (rst_n && reg_re) begin n_re <= n_re + 1; r_addr <= reg_addr; r_cl <= reg_clockless; end
   end

   logic [7:0] fr [16];
   logic [7:0] ex [16];
   logic [7:0] rs [16];
   int fn;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7(input int n);
      logic [6:0] c = 7'h7F;
      for (int i = 0; i < n; i++)
         for (int k = 7; k >= 0; k--) begin
            logic fb = c[6] ^ fr[i][k];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
         end
      return c;
   endfunction

   task automatic xfer(input logic [7:0] b, output logic [7:0] got);
      @(negedge clk);
      got = tx_byte;
      rx_byte = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // sends fr[0..fn-1] (+CRC when enabled), then n_rsp zero slots into rs
   task automatic send(input int n_rsp, input bit add_crc);
      logic [7:0] g;
      logic [7:0] quiet = 8'h00;
      if (add_crc && crc_en) begin fr[fn] = {crc7(fn), 1'b0}; fn++; end
      for (int i = 0; i < fn; i++) begin xfer(fr[i], g); if (i > 0) quiet |= g; end
      if (fn > 1) chk("R10", "tx during frame", {24'd0, quiet}, 32'h0);
      for (int i = 0; i < n_rsp; i++) xfer(8'h00, rs[i]);
   endtask

   task automatic cmp_rsp(input string req, input int n);
      for (int i = 0; i < n; i++) chk(req, $sformatf("rsp byte %0d", i), {24'd0, rs[i]}, {24'd0, ex[i]});
   endtask

   task automatic t_reset;
      chk("R1", "tx after reset", {24'd0, tx_byte}, 32'h0);
      chk("R1", "no access", {30'd0, reg_we, reg_re}, 32'h0);
   endtask

   task automatic t_single_write;
      int we0 = n_we;
      crc_en = 1'b1;
      fr[0]=8'hC9; fr[1]=8'h12; fr[2]=8'h34; fr[3]=8'h56;
      fr[4]=8'hDE; fr[5]=8'hAD; fr[6]=8'hBE; fr[7]=8'hEF; fn = 8;
      send(2, 1'b1);
      ex[0]=8'hC9; ex[1]=8'h00; cmp_rsp("R2", 2);
      chk("R2", "write count", n_we - we0, 1);
      chk("R2", "write addr", {8'd0, w_addr}, 32'h123456);
      chk("R2", "write data", w_data, 32'hDEADBEEF);
      chk("R2", "clockless", {31'd0, w_cl}, 0);
   endtask

   task automatic t_single_read(input bit crc);
      int re0 = n_re;
      logic [31:0] d = mem_val(24'h010203);
      crc_en = crc;
      fr[0]=8'hCA; fr[1]=8'h01; fr[2]=8'h02; fr[3]=8'h03; fn = 4;
      send(crc ? 9 : 7, 1'b1);
      ex[0]=8'hCA; ex[1]=8'h00; ex[2]=8'hF3;
      ex[3]=d[31:24]; ex[4]=d[23:16]; ex[5]=d[15:8]; ex[6]=d[7:0]; ex[7]=8'h00; ex[8]=8'h00;
      cmp_rsp(crc ? "R3" : "R7", crc ? 9 : 7);
      chk("R3", "read count", n_re - re0, 1);
      chk("R3", "read addr", {8'd0, r_addr}, 32'h010203);
   endtask

   task automatic t_internal;
      logic [31:0] d = mem_val(24'h000110);
      crc_en = 1'b1;
      fr[0]=8'hC3; fr[1]=8'h80; fr[2]=8'h24; fr[3]=8'h11; fr[4]=8'h22; fr[5]=8'h33; fr[6]=8'h44; fn = 7;
      send(2, 1'b1);
      ex[0]=8'hC3; ex[1]=8'h00; cmp_rsp("R4", 2);
      chk("R4", "int write addr", {8'd0, w_addr}, 32'h000024);
      chk("R4", "int write data", w_data, 32'h11223344);
      chk("R4", "int write clockless", {31'd0, w_cl}, 1);
      fr[0]=8'hC4; fr[1]=8'h81; fr[2]=8'h10; fr[3]=8'h77; fn = 4;
      send(9, 1'b1);
      ex[0]=8'hC4; ex[1]=8'h00; ex[2]=8'hF3;
      ex[3]=d[31:24]; ex[4]=d[23:16]; ex[5]=d[15:8]; ex[6]=d[7:0];
      cmp_rsp("R4", 9);
      chk("R4", "int read addr", {8'd0, r_addr}, 32'h000110);
      chk("R4", "int read clockless", {31'd0, r_cl}, 1);
   endtask

   task automatic t_dma;
      int we0 = n_we, re0 = n_re;
      crc_en = 1'b1;
      fr[0]=8'hC2; fr[1]=8'h00; fr[2]=8'h10; fr[3]=8'h00; fr[4]=8'h01; fr[5]=8'h00; fn = 6;
      send(2, 1'b1);
      ex[0]=8'hC2; ex[1]=8'h00; cmp_rsp("R5", 2);
      fr[0]=8'hC7; fr[1]=8'h00; fr[2]=8'h20; fr[3]=8'h00; fr[4]=8'h00; fr[5]=8'h40; fr[6]=8'h00; fn = 7;
      send(2, 1'b1);
      ex[0]=8'hC7; cmp_rsp("R5", 2);
      chk("R5", "no access", (n_we - we0) + (n_re - re0), 0);
   endtask

   task automatic t_ctrl;
      int we0 = n_we, re0 = n_re;
      crc_en = 1'b1;
      fr[0]=8'hCF; fr[1]=8'hFF; fr[2]=8'hFF; fr[3]=8'hFF; fn = 4;
      send(3, 1'b1);
      ex[0]=8'h00; ex[1]=8'hCF; ex[2]=8'h00; cmp_rsp("R6", 3);
      crc_en = 1'b0;
      fr[0]=8'hC5; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h00; fn = 4;
      send(3, 1'b1);
      ex[1]=8'hC5; cmp_rsp("R6", 3);
      crc_en = 1'b1;
      fr[0]=8'hC6; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h00; fn = 4;
      send(3, 1'b1);
      ex[1]=8'hC6; cmp_rsp("R6", 3);
      chk("R6", "no access", (n_we - we0) + (n_re - re0), 0);
   endtask

   task automatic t_bad_crc;
      int we0 = n_we;
      crc_en = 1'b1;
      fr[0]=8'hC9; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h40;
      fr[4]=8'h01; fr[5]=8'h02; fr[6]=8'h03; fr[7]=8'h04; fn = 8;
      fr[8] = {crc7(8), 1'b0} ^ 8'h02; fn = 9;
      send(2, 1'b0);
      ex[0]=8'hC9; ex[1]=8'h02; cmp_rsp("R7", 2);
      chk("R7", "no write on bad crc", n_we - we0, 0);
   endtask

   task automatic t_bad_op;
      int we0 = n_we, re0 = n_re;
      fr[0]=8'h55; fn = 1;
      send(2, 1'b0);
      ex[0]=8'h55; ex[1]=8'h01; cmp_rsp("R8", 2);
      chk("R8", "no access", (n_we - we0) + (n_re - re0), 0);
      crc_en = 1'b0;
      fr[0]=8'hC6; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h00; fn = 4;
      send(3, 1'b1);
      ex[0]=8'h00; ex[1]=8'hC6; ex[2]=8'h00; cmp_rsp("R8", 3);
   endtask

   task automatic t_abort;
      logic [7:0] g;
      int we0 = n_we;
      crc_en = 1'b0;
      xfer(8'hC9, g); xfer(8'hAA, g); xfer(8'hBB, g);
      @(negedge clk); cs_n = 1'b1;
      xfer(8'h11, g);
      chk("R9", "tx while deselected", {24'd0, tx_byte}, 32'h0);
      @(negedge clk); cs_n = 1'b0;
      fr[0]=8'hC9; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h99;
      fr[4]=8'hCA; fr[5]=8'hFE; fr[6]=8'hBA; fr[7]=8'hBE; fn = 8;
      send(2, 1'b1);
      ex[0]=8'hC9; ex[1]=8'h00; cmp_rsp("R9", 2);
      chk("R9", "one write after abort", n_we - we0, 1);
      chk("R9", "fresh addr", {8'd0, w_addr}, 32'h000099);
      fr[0]=8'hCA; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h01; fn = 4;
      send(3, 1'b1);
      @(negedge clk); cs_n = 1'b1;
      repeat (2) @(negedge clk); cs_n = 1'b0;
      fr[0]=8'hC5; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h00; fn = 4;
      send(3, 1'b1);
      ex[0]=8'h00; ex[1]=8'hC5; ex[2]=8'h00; cmp_rsp("R9", 3);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; rx_valid = 1'b0; rx_byte = 8'h00; crc_en = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      cs_n = 1'b0;
      t_single_write();
      t_single_read(1'b1);
      t_single_read(1'b0);
      t_internal();
      t_dma();
      t_ctrl();
      t_bad_crc();
      t_bad_op();
      t_abort();
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule